// File: doc/BRIEF.md
# Virtualized Time Counter CSR Unit

This unit serves the read-only wall-clock counter CSRs of a hart that implements the hypervisor extension, and it holds the hypervisor's writable 64-bit guest time offset. A platform timer broadcasts a 64-bit time value together with a strobe. The unit keeps a local copy of that value and uses the copy for two things. It answers CSR reads from the copy, and it compares the copy against this hart's compare value to drive the machine timer-pending bit.

When the hart runs with the virtualization bit set, a counter read returns the local copy plus the guest offset. The addition wraps modulo 2^64. Otherwise the read returns the raw copy. With a 32-bit XLEN, the low and high halves of the counter and of the offset each have their own address: counter low at 0xC01, counter high at 0xC81, offset low at 0x605 and offset high at 0x615. The read path is combinational. Offset writes take effect at the next clock edge. A write to a counter address is refused and flagged. Counter addresses are decoded only while the basic counters are enabled, and offset addresses only while the hypervisor extension is enabled.

Top module: `vtime_csr_unit`

## Requirements
- R1: After a synchronous reset, the time copy and the offset read as 0 at all four addresses, and the timer-pending output is 0.
- R2: On a clock edge where `mtime_valid` is 1, the time copy takes `mtime_in`. When `mtime_valid` is 0, the copy holds its value whatever `mtime_in` does.
- R3: With `virt_mode`=0, address 0xC01 reads bits 31:0 of the time copy and address 0xC81 reads bits 63:32.
- R4: With `virt_mode`=1, both 0xC01 and 0xC81 read slices of the single 64-bit sum of the copy and the offset. The carry from the low half reaches the high half, and the sum wraps modulo 2^64 with no flag.
- R5: A write (`csr_we`=1) to 0xC01 or 0xC81 raises `csr_wr_fail` in the same cycle with `csr_hit`=1, and it changes neither the time copy nor the offset.
- R6: A write to 0x605 loads offset bits 31:0 and a write to 0x615 loads offset bits 63:32. Each write takes effect at the next edge and leaves the other half unchanged.
- R7: With `cntr_en`=0, addresses 0xC01 and 0xC81 are not decoded: `csr_hit`=0, `csr_rdata`=0 and `csr_wr_fail`=0.
- R8: With `hyp_en`=0, addresses 0x605 and 0x615 are not decoded (`csr_hit`=0), and writes to them leave the offset unchanged.
- R9: `mtip` is registered and equals the unsigned comparison (time copy >= `mtimecmp_in`) taken one clock edge earlier.
- R10: Any address outside the four above gives `csr_hit`=0, `csr_rdata`=0 and `csr_wr_fail`=0.
- R11: Reads of 0x605 and 0x615 return the stored offset whatever the value of `virt_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mtime_valid | input | 1 | Strobe: a new platform time value is present |
| mtime_in | input | 64 | Broadcast platform time value |
| mtimecmp_in | input | 64 | This hart's timer compare value |
| virt_mode | input | 1 | Virtualization bit of the current privilege mode |
| cntr_en | input | 1 | Basic counter CSRs are enabled |
| hyp_en | input | 1 | Hypervisor extension is enabled |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | CSR write request |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| csr_hit | output | 1 | Address is decoded by this unit |
| csr_wr_fail | output | 1 | Write to a read-only counter address was refused |
| mtip | output | 1 | Machine timer-pending bit |

## Verification
Some behaviours are checked on every cycle. These are the gating of each address pair by its enable, zero read data on a miss, the refusal flag for counter writes, the load-or-hold rule for the time copy, and the one-cycle registered compare behind `mtip`. Other behaviours show only in the bench's scenarios. These are the carry from the low to the high half and the 2^64 wrap of the guest sum, the independence of the two offset halves, and the fact that refused or undecoded writes leave the stored state untouched, which the bench shows by reading the state back afterwards.

// File: rtl/vtime_pkg.sv
package vtime_pkg;
  localparam int unsigned TW = 64;

  localparam logic [11:0] ADDR_CNT_LO = 12'hC01;
  localparam logic [11:0] ADDR_CNT_HI = 12'hC81;
  localparam logic [11:0] ADDR_OFS_LO = 12'h605;
  localparam logic [11:0] ADDR_OFS_HI = 12'h615;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_CNT_LO = 3'd1,
    SEL_CNT_HI = 3'd2,
    SEL_OFS_LO = 3'd3,
    SEL_OFS_HI = 3'd4
  } csr_sel_e;
endpackage

// File: rtl/vtime_decode.sv
module vtime_decode
  import vtime_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [11:0] addr,
  input  logic        cntr_en,
  input  logic        hyp_en,
  output csr_sel_e    sel
);
  localparam bit HAS_HI = (XLEN == 32);

  always_comb begin
    sel = SEL_NONE;
    if (cntr_en && addr == ADDR_CNT_LO)
      sel = SEL_CNT_LO;
    else if (cntr_en && HAS_HI && addr == ADDR_CNT_HI)
      sel = SEL_CNT_HI;
    else if (hyp_en && addr == ADDR_OFS_LO)
      sel = SEL_OFS_LO;
    else if (hyp_en && HAS_HI && addr == ADDR_OFS_HI)
      sel = SEL_OFS_HI;
  end
endmodule

// File: rtl/vtime_shadow.sv
module vtime_shadow #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (load)
      q <= din;
  end
endmodule

// File: rtl/vtime_offset.sv
module vtime_offset #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned W    = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [XLEN-1:0] wdata,
  output logic [W-1:0]    q
);
  localparam int unsigned HALF = W / 2;

  generate
    if (XLEN < W) begin : g_split
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else begin
          if (wr_lo) q[HALF-1:0] <= wdata[HALF-1:0];
          if (wr_hi) q[W-1:HALF] <= wdata[HALF-1:0];
        end
      end
    end else begin : g_full
      logic unused_hi;
      assign unused_hi = wr_hi;
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (wr_lo)
          q <= wdata[W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/vtime_cmp.sv
module vtime_cmp #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] now,
  input  logic [W-1:0] limit,
  output logic         pend
);
  always_ff @(posedge clk) begin
    if (rst)
      pend <= 1'b0;
    else
      pend <= (now >= limit);
  end
endmodule

// File: rtl/vtime_csr_unit.sv
module vtime_csr_unit
  import vtime_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mtime_valid,
  input  logic [63:0]     mtime_in,
  input  logic [63:0]     mtimecmp_in,
  input  logic            virt_mode,
  input  logic            cntr_en,
  input  logic            hyp_en,
  input  logic [11:0]     csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_hit,
  output logic            csr_wr_fail,
  output logic            mtip
);
  csr_sel_e      sel;
  logic [TW-1:0] time_copy;
  logic [TW-1:0] offset_q;
  logic [TW-1:0] view_sum;
  logic          wr_ofs_lo;
  logic          wr_ofs_hi;

  vtime_decode #(.XLEN(XLEN)) u_decode (
    .addr    (csr_addr),
    .cntr_en (cntr_en),
    .hyp_en  (hyp_en),
    .sel     (sel)
  );

  vtime_shadow #(.W(TW)) u_shadow (
    .clk  (clk),
    .rst  (rst),
    .load (mtime_valid),
    .din  (mtime_in),
    .q    (time_copy)
  );

  assign wr_ofs_lo = csr_we && (sel == SEL_OFS_LO);
  assign wr_ofs_hi = csr_we && (sel == SEL_OFS_HI);

  vtime_offset #(.XLEN(XLEN), .W(TW)) u_offset (
    .clk   (clk),
    .rst   (rst),
    .wr_lo (wr_ofs_lo),
    .wr_hi (wr_ofs_hi),
    .wdata (csr_wdata),
    .q     (offset_q)
  );

  vtime_cmp #(.W(TW)) u_cmp (
    .clk   (clk),
    .rst   (rst),
    .now   (time_copy),
    .limit (mtimecmp_in),
    .pend  (mtip)
  );

  assign view_sum = time_copy + (virt_mode ? offset_q : '0);

  always_comb begin
    unique case (sel)
      SEL_CNT_LO: csr_rdata = view_sum[XLEN-1:0];
      SEL_CNT_HI: csr_rdata = view_sum[TW-1 -: XLEN];
      SEL_OFS_LO: csr_rdata = offset_q[XLEN-1:0];
      SEL_OFS_HI: csr_rdata = offset_q[TW-1 -: XLEN];
      default:    csr_rdata = '0;
    endcase
  end

  assign csr_hit     = (sel != SEL_NONE);
  assign csr_wr_fail = csr_we && ((sel == SEL_CNT_LO) || (sel == SEL_CNT_HI));
endmodule

// File: rtl/vtime_csr_checker.sv
module vtime_csr_checker #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            mtime_valid,
  input logic [63:0]     mtime_in,
  input logic [63:0]     mtimecmp_in,
  input logic            cntr_en,
  input logic            hyp_en,
  input logic [11:0]     csr_addr,
  input logic            csr_we,
  input logic [XLEN-1:0] csr_rdata,
  input logic            csr_hit,
  input logic            csr_wr_fail,
  input logic            mtip,
  input logic [63:0]     time_copy
);
  logic cnt_addr;
  logic ofs_addr;
  assign cnt_addr = (csr_addr == 12'hC01) || (XLEN == 32 && csr_addr == 12'hC81);
  assign ofs_addr = (csr_addr == 12'h605) || (XLEN == 32 && csr_addr == 12'h615);

  AST_TIME_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mtime_valid)) |-> time_copy == $past(mtime_in)); // R2
  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mtime_valid)) |-> $stable(time_copy)); // R2
  AST_WR_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (csr_we && cntr_en && cnt_addr) |-> (csr_wr_fail && csr_hit)); // R5
  AST_FAIL_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    csr_wr_fail |-> (csr_we && cntr_en && cnt_addr)); // R5
  AST_CNT_GATED: assert property (@(posedge clk) disable iff (rst)
    (!cntr_en && cnt_addr) |-> (!csr_hit && !csr_wr_fail)); // R7
  AST_OFS_GATED: assert property (@(posedge clk) disable iff (rst)
    (!hyp_en && ofs_addr) |-> !csr_hit); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !csr_hit |-> (csr_rdata == '0)); // R10
  AST_MTIP_TRACK: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mtip == ($past(time_copy) >= $past(mtimecmp_in)))); // R9
endmodule

bind vtime_csr_unit vtime_csr_checker #(.XLEN(XLEN)) u_checker (
  .clk         (clk),
  .rst         (rst),
  .mtime_valid (mtime_valid),
  .mtime_in    (mtime_in),
  .mtimecmp_in (mtimecmp_in),
  .cntr_en     (cntr_en),
  .hyp_en      (hyp_en),
  .csr_addr    (csr_addr),
  .csr_we      (csr_we),
  .csr_rdata   (csr_rdata),
  .csr_hit     (csr_hit),
  .csr_wr_fail (csr_wr_fail),
  .mtip        (mtip),
  .time_copy   (time_copy)
);

// File: tb/vtime_csr_unit_bench.sv
module vtime_csr_unit_bench;
  localparam int unsigned XLEN = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic            mtime_valid;
  logic [63:0]     mtime_in;
  logic [63:0]     mtimecmp_in;
  logic            virt_mode;
  logic            cntr_en;
  logic            hyp_en;
  logic [11:0]     csr_addr;
  logic            csr_we;
  logic [XLEN-1:0] csr_wdata;
  logic [XLEN-1:0] csr_rdata;
  logic            csr_hit;
  logic            csr_wr_fail;
  logic            mtip;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  vtime_csr_unit #(.XLEN(XLEN)) u_vtime_csr_unit (
    .clk(clk), .rst(rst), .mtime_valid(mtime_valid), .mtime_in(mtime_in),
    .mtimecmp_in(mtimecmp_in), .virt_mode(virt_mode), .cntr_en(cntr_en),
    .hyp_en(hyp_en), .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .csr_hit(csr_hit), .csr_wr_fail(csr_wr_fail), .mtip(mtip)
  );

  typedef struct packed {
    logic [63:0] mt;
    logic [63:0] dl;
    logic        v;
    logic [11:0] a;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0001_0000_0005, 64'h0, 1'b0, 12'hC01, 32'h0000_0005, 8'd3},                     // R3
    '{64'h0000_0001_0000_0005, 64'h0, 1'b0, 12'hC81, 32'h0000_0001, 8'd3},                     // R3
    '{64'h0000_0000_FFFF_FFFF, 64'h1, 1'b1, 12'hC81, 32'h0000_0001, 8'd4},                     // R4 carry
    '{64'h0000_0000_FFFF_FFFF, 64'h1, 1'b1, 12'hC01, 32'h0000_0000, 8'd4},                     // R4
    '{64'h0000_0000_FFFF_FFFF, 64'h1, 1'b0, 12'hC81, 32'h0000_0000, 8'd3},                     // R3 raw
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 1'b1, 12'hC01, 32'h0000_0001, 8'd4},                     // R4 wrap
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 1'b1, 12'hC81, 32'h0000_0000, 8'd4},                     // R4 wrap
    '{64'h1234_5678_9ABC_DEF0, 64'h0000_0001_0000_0010, 1'b1, 12'hC01, 32'h9ABC_DF00, 8'd4},   // R4
    '{64'h1234_5678_9ABC_DEF0, 64'h0000_0001_0000_0010, 1'b1, 12'hC81, 32'h1234_5679, 8'd4},   // R4
    '{64'h1234_5678_9ABC_DEF0, 64'h0000_0001_0000_0010, 1'b1, 12'h605, 32'h0000_0010, 8'd11},  // R11
    '{64'h1234_5678_9ABC_DEF0, 64'h0000_0001_0000_0010, 1'b0, 12'h615, 32'h0000_0001, 8'd11}   // R11
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_time(input logic [63:0] v);
    mtime_in = v; mtime_valid = 1'b1;
    tick();
    mtime_valid = 1'b0;
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    tick();
    csr_we = 1'b0;
  endtask

  task automatic read_at(input logic [11:0] a, input logic v, output logic [31:0] d);
    csr_addr = a; virt_mode = v;
    #1 d = csr_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; mtime_valid = 1'b0; mtime_in = 64'h5555; mtimecmp_in = 64'd100;
    virt_mode = 1'b0; cntr_en = 1'b1; hyp_en = 1'b1;
    csr_addr = 12'h000; csr_we = 1'b0; csr_wdata = '0;
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    // R1 reset state
    read_at(12'hC01, 1'b0, d); chk("R1 time lo", d, 0);
    read_at(12'hC81, 1'b0, d); chk("R1 time hi", d, 0);
    read_at(12'h605, 1'b0, d); chk("R1 offset lo", d, 0);
    read_at(12'h615, 1'b0, d); chk("R1 offset hi", d, 0);
    chk("R1 mtip", mtip, 0);

    // vector walk (R3 R4 R11; offsets loaded via R6 path)
    for (int i = 0; i < NV; i++) begin
      csr_write(12'h605, VECS[i].dl[31:0]);
      csr_write(12'h615, VECS[i].dl[63:32]);
      load_time(VECS[i].mt);
      read_at(VECS[i].a, VECS[i].v, d);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].exp);
    end

    // R2 hold when strobe low
    load_time(64'h0000_0007_0000_0009);
    mtime_in = 64'hDEAD_BEEF_0000_0001; tick();
    read_at(12'hC01, 1'b0, d); chk("R2 hold lo", d, 32'h9);
    read_at(12'hC81, 1'b0, d); chk("R2 hold hi", d, 32'h7);

    // R6 independent halves
    csr_write(12'h605, 32'hAAAA_0000);
    csr_write(12'h615, 32'h0000_BBBB);
    csr_write(12'h605, 32'h1111_2222);
    read_at(12'h615, 1'b0, d); chk("R6 hi kept", d, 32'h0000_BBBB);
    read_at(12'h605, 1'b0, d); chk("R6 lo new", d, 32'h1111_2222);

    // R5 refused write
    csr_addr = 12'hC01; csr_wdata = 32'hFFFF_FFFF; csr_we = 1'b1; #1;
    chk("R5 fail flag", csr_wr_fail, 1);
    chk("R5 hit", csr_hit, 1);
    tick(); csr_we = 1'b0;
    read_at(12'hC01, 1'b0, d); chk("R5 time kept", d, 32'h9);
    read_at(12'h605, 1'b0, d); chk("R5 offset kept", d, 32'h1111_2222);
    csr_addr = 12'hC81; csr_we = 1'b1; #1;
    chk("R5 fail flag hi", csr_wr_fail, 1);
    tick(); csr_we = 1'b0;
    read_at(12'hC81, 1'b0, d); chk("R5 time hi kept", d, 32'h7);

    // R7 counters disabled
    cntr_en = 1'b0;
    csr_addr = 12'hC01; csr_we = 1'b1; #1;
    chk("R7 hit", csr_hit, 0);
    chk("R7 fail", csr_wr_fail, 0);
    chk("R7 rdata", csr_rdata, 0);
    tick(); csr_we = 1'b0; cntr_en = 1'b1;

    // R8 hypervisor disabled
    hyp_en = 1'b0;
    csr_addr = 12'h605; #1; chk("R8 hit", csr_hit, 0);
    csr_write(12'h605, 32'h0BAD_0BAD);
    hyp_en = 1'b1;
    read_at(12'h605, 1'b0, d); chk("R8 offset kept", d, 32'h1111_2222);

    // R10 unrelated address
    csr_addr = 12'h123; csr_we = 1'b1; #1;
    chk("R10 hit", csr_hit, 0);
    chk("R10 rdata", csr_rdata, 0);
    chk("R10 fail", csr_wr_fail, 0);
    tick(); csr_we = 1'b0;

    // R9 compare
    mtimecmp_in = 64'd100;
    load_time(64'd99); tick(); chk("R9 below", mtip, 0);
    load_time(64'd100); tick(); chk("R9 equal", mtip, 1);
    load_time(64'hFFFF_FFFF_FFFF_FFFF); tick(); chk("R9 unsigned max", mtip, 1);
    mtimecmp_in = 64'h8000_0000_0000_0000;
    load_time(64'd5); tick(); chk("R9 high cmp", mtip, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule